// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the memory traffic a CPU core needs when it enters an exception handler. Once a request is pending and the core reports that the instruction in flight has retired, the sequencer captures the core's context and writes it byte by byte onto a downward-growing stack. It then fetches a 16-bit handler address from a table of two-byte entries in low memory. When the handler address is in hand, it presents the new program counter and stack pointer and pulses a completion strobe.

Two context sizes are supported. In the small-memory mode only the program counter and the status byte are saved. In the large-memory mode the code bank byte is saved first. A table entry has no bank field, so the fetched value is a plain 16-bit program counter. Index 0 is the reset entry: it saves nothing and only reads its table entry. The memory side is a byte-wide port with a request/ready handshake that allows one access in flight.

Top module: `exc_entry_seq`

## Requirements
- R1: While `req_valid` is high but `instr_done` is low, the sequencer stays idle (`busy` low) and issues no memory request. A request is taken on the first rising edge where both are high.
- R2: With `mode_max` = 0 and a nonzero index, the sequencer makes three byte writes. The PC high byte goes to SP-1, the PC low byte to SP-2 and the status byte to SP-3, in that order.
- R3: With `mode_max` = 1 and a nonzero index, the sequencer makes four byte writes. The bank byte goes to SP-1, the PC high byte to SP-2, the PC low byte to SP-3 and the status byte to SP-4, in that order.
- R4: After the writes, the sequencer makes two reads. The first is at address 2·index (low byte) and the second at 2·index+1 (high byte), both zero-extended to the address width.
- R5: One cycle after the high vector byte is accepted, `done` is high for exactly one cycle. At that point `new_pc` = {high byte, low byte}, `new_sp` = SP minus the number of bytes written, and `busy` is low.
- R6: Index 0 makes no writes. The two reads happen at addresses 0 and 1, and `new_sp` equals the captured SP.
- R7: While `mem_req` is high and `mem_ready` is low, the address, write enable and write data hold steady. Only one access is outstanding at a time.
- R8: A request, or a change to the context inputs, that arrives while `busy` is high has no effect on the sequence in progress. The sequence uses the index, mode and context captured when the request was taken.
- R9: After reset, `mem_req`, `done` and `busy` are low, and `new_pc` and `new_sp` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request pending |
| instr_done | input | 1 | Current instruction has completed |
| req_index | input | IDX_W | Table index chosen by the priority logic |
| mode_max | input | 1 | 1 = also save the code bank byte |
| cur_pc | input | 16 | Program counter to save |
| cur_sc | input | 8 | Status byte to save |
| cur_cb | input | 8 | Code bank byte to save |
| cur_sp | input | SP_W | Stack pointer before entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access accepted on this edge |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| new_pc | output | 16 | Handler address |
| new_sp | output | SP_W | Stack pointer after the writes |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Sequence in progress |

## Verification
A request is taken on the edge where `req_valid` and `instr_done` are both high. The first access request is visible after that edge. Each access ends on the edge where `mem_ready` is high, and the next access is presented right after that edge. `done`, `new_pc` and `new_sp` change on the edge after the high vector byte is accepted. The bench drives inputs and the memory model's ready and samples all outputs on falling edges, so every value is read half a cycle after the edge that set it. The memory model logs each accepted access. After `done`, the bench compares the log entry by entry with addresses and bytes it computed from SP, index and mode.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VLO,
    ST_VHI
  } exc_state_t;

  typedef enum logic [1:0] {
    SLOT_BANK,
    SLOT_PCH,
    SLOT_PCL,
    SLOT_STAT
  } push_slot_t;
endpackage

// File: rtl/exc_ctx_hold.sv
module exc_ctx_hold #(
  parameter int IDX_W = 7,
  parameter int SP_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [IDX_W-1:0]          in_idx,
  input  logic                      in_mode,
  input  logic [exc_pkg::PC_W-1:0]  in_pc,
  input  logic [exc_pkg::BYTE_W-1:0] in_sc,
  input  logic [exc_pkg::BYTE_W-1:0] in_cb,
  input  logic [SP_W-1:0]           in_sp,
  output logic [IDX_W-1:0]          q_idx,
  output logic                      q_mode,
  output logic [exc_pkg::PC_W-1:0]  q_pc,
  output logic [exc_pkg::BYTE_W-1:0] q_sc,
  output logic [exc_pkg::BYTE_W-1:0] q_cb,
  output logic [SP_W-1:0]           q_sp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_idx  <= '0;
      q_mode <= 1'b0;
      q_pc   <= '0;
      q_sc   <= '0;
      q_cb   <= '0;
      q_sp   <= '0;
    end else if (load) begin
      q_idx  <= in_idx;
      q_mode <= in_mode;
      q_pc   <= in_pc;
      q_sc   <= in_sc;
      q_cb   <= in_cb;
      q_sp   <= in_sp;
    end
  end
endmodule

// File: rtl/exc_push_slot.sv
module exc_push_slot #(
  parameter int SP_W   = 16,
  parameter int ADDR_W = 24
) (
  input  logic [1:0]                 step,
  input  logic                       mode_max,
  input  logic [exc_pkg::PC_W-1:0]   pc,
  input  logic [exc_pkg::BYTE_W-1:0] sc,
  input  logic [exc_pkg::BYTE_W-1:0] cb,
  input  logic [SP_W-1:0]            sp,
  output logic [ADDR_W-1:0]          addr,
  output logic [exc_pkg::BYTE_W-1:0] wdata
);
  import exc_pkg::*;

  push_slot_t       slot;
  logic [SP_W-1:0]  waddr;

  // Minimum mode starts one slot later, skipping the bank byte.
  assign slot  = push_slot_t'(mode_max ? step : step + 2'd1);
  assign waddr = sp - SP_W'({1'b0, step} + 3'd1);

  generate
    if (ADDR_W >= SP_W) begin : g_ext
      assign addr = ADDR_W'(waddr);
    end else begin : g_trunc
      assign addr = waddr[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (slot)
      SLOT_BANK: wdata = cb;
      SLOT_PCH:  wdata = pc[PC_W-1 -: BYTE_W];
      SLOT_PCL:  wdata = pc[BYTE_W-1:0];
      default:   wdata = sc;
    endcase
  end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 24
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              hi_sel,
  output logic [ADDR_W-1:0] addr
);
  localparam int RAW_W = IDX_W + 1;
  logic [RAW_W-1:0] raw;

  assign raw = {idx, hi_sel};

  generate
    if (ADDR_W >= RAW_W) begin : g_ext
      assign addr = ADDR_W'(raw);
    end else begin : g_trunc
      assign addr = raw[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int IDX_W  = 7,
  parameter int SP_W   = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              instr_done,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              mode_max,
  input  logic [15:0]       cur_pc,
  input  logic [7:0]        cur_sc,
  input  logic [7:0]        cur_cb,
  input  logic [SP_W-1:0]   cur_sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       new_pc,
  output logic [SP_W-1:0]   new_sp,
  output logic              done,
  output logic              busy
);
  import exc_pkg::*;

  localparam logic [1:0] LAST_MAX = 2'd3;
  localparam logic [1:0] LAST_MIN = 2'd2;

  exc_state_t       state;
  logic [1:0]       step;
  logic [7:0]       vec_lo;
  logic             take;
  logic             idle;

  logic [IDX_W-1:0] h_idx;
  logic             h_mode;
  logic [15:0]      h_pc;
  logic [7:0]       h_sc;
  logic [7:0]       h_cb;
  logic [SP_W-1:0]  h_sp;

  logic [IDX_W-1:0] c_idx;
  logic             c_mode;
  logic [15:0]      c_pc;
  logic [7:0]       c_sc;
  logic [7:0]       c_cb;
  logic [SP_W-1:0]  c_sp;

  logic [1:0]        nstep;
  logic [ADDR_W-1:0] push_addr;
  logic [7:0]        push_data;
  logic [ADDR_W-1:0] vec_addr;
  logic              last_push;
  logic [2:0]        push_cnt;

  assign idle = (state == ST_IDLE);
  assign take = idle && req_valid && instr_done;
  assign busy = !idle;

  exc_ctx_hold #(.IDX_W(IDX_W), .SP_W(SP_W)) i_hold (
    .clk(clk), .rst(rst), .load(take),
    .in_idx(req_index), .in_mode(mode_max), .in_pc(cur_pc),
    .in_sc(cur_sc), .in_cb(cur_cb), .in_sp(cur_sp),
    .q_idx(h_idx), .q_mode(h_mode), .q_pc(h_pc),
    .q_sc(h_sc), .q_cb(h_cb), .q_sp(h_sp)
  );

  // In idle the first access is formed straight from the live inputs.
  assign c_idx  = idle ? req_index : h_idx;
  assign c_mode = idle ? mode_max  : h_mode;
  assign c_pc   = idle ? cur_pc    : h_pc;
  assign c_sc   = idle ? cur_sc    : h_sc;
  assign c_cb   = idle ? cur_cb    : h_cb;
  assign c_sp   = idle ? cur_sp    : h_sp;

  assign nstep     = idle ? 2'd0 : step + 2'd1;
  assign last_push = (step == (h_mode ? LAST_MAX : LAST_MIN));
  assign push_cnt  = (h_idx == '0) ? 3'd0 : (h_mode ? 3'd4 : 3'd3);

  exc_push_slot #(.SP_W(SP_W), .ADDR_W(ADDR_W)) i_slot (
    .step(nstep), .mode_max(c_mode), .pc(c_pc), .sc(c_sc), .cb(c_cb),
    .sp(c_sp), .addr(push_addr), .wdata(push_data)
  );

  exc_vec_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_vec (
    .idx(c_idx), .hi_sel(state == ST_VLO), .addr(vec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= 2'd0;
      vec_lo    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      new_pc    <= '0;
      new_sp    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            mem_req <= 1'b1;
            step    <= 2'd0;
            if (req_index == '0) begin
              state    <= ST_VLO;
              mem_we   <= 1'b0;
              mem_addr <= vec_addr;
            end else begin
              state     <= ST_PUSH;
              mem_we    <= 1'b1;
              mem_addr  <= push_addr;
              mem_wdata <= push_data;
            end
          end
        end
        ST_PUSH: begin
          if (mem_ready) begin
            if (last_push) begin
              state    <= ST_VLO;
              mem_we   <= 1'b0;
              mem_addr <= vec_addr;
            end else begin
              step      <= nstep;
              mem_addr  <= push_addr;
              mem_wdata <= push_data;
            end
          end
        end
        ST_VLO: begin
          if (mem_ready) begin
            vec_lo   <= mem_rdata;
            mem_addr <= vec_addr;
            state    <= ST_VHI;
          end
        end
        default: begin
          if (mem_ready) begin
            new_pc  <= {mem_rdata, vec_lo};
            new_sp  <= h_sp - SP_W'(push_cnt);
            done    <= 1'b1;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int IDX_W  = 7,
  parameter int SP_W   = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              instr_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              done,
  input logic              busy
);
  // R1
  idle_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && instr_done)) |=> !mem_req);

  // R7
  hold_access_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  // R4
  vec_region_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr < ADDR_W'(2 ** (IDX_W + 1))));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .IDX_W(IDX_W), .SP_W(SP_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .instr_done(instr_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .done(done), .busy(busy)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int IDX_W  = 7;
  localparam int SP_W   = 16;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              instr_done = 1'b0;
  logic [IDX_W-1:0]  req_index = '0;
  logic              mode_max = 1'b0;
  logic [15:0]       cur_pc = '0;
  logic [7:0]        cur_sc = '0;
  logic [7:0]        cur_cb = '0;
  logic [SP_W-1:0]   cur_sp = '0;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic              mem_ready = 1'b0;
  logic [7:0]        mem_rdata;
  logic [15:0]       new_pc;
  logic [SP_W-1:0]   new_sp;
  logic              done, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  exc_entry_seq #(.IDX_W(IDX_W), .SP_W(SP_W), .ADDR_W(ADDR_W)) i_exc_entry_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .instr_done(instr_done),
    .req_index(req_index), .mode_max(mode_max), .cur_pc(cur_pc),
    .cur_sc(cur_sc), .cur_cb(cur_cb), .cur_sp(cur_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .new_pc(new_pc), .new_sp(new_sp), .done(done), .busy(busy)
  );

  function automatic logic [7:0] vec_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  assign mem_rdata = vec_byte(mem_addr);

  // Memory model: logs every accepted access in a 16-entry ring.
  int                lat = 0;
  int                wcnt = 0;
  int                log_n = 0;
  int                hold_bad = 0;
  logic [ADDR_W-1:0] log_addr [16];
  logic              log_we   [16];
  logic [7:0]        log_wd   [16];
  logic [ADDR_W-1:0] snap_addr;
  logic [7:0]        snap_wd;
  logic              snap_we;

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        snap_addr = mem_addr;
        snap_wd   = mem_wdata;
        snap_we   = mem_we;
      end
      if (wcnt == lat) begin
        if (snap_addr != mem_addr || snap_we != mem_we ||
            (mem_we && snap_wd != mem_wdata)) hold_bad++;
        log_addr[log_n % 16] = mem_addr;
        log_we[log_n % 16]   = mem_we;
        log_wd[log_n % 16]   = mem_wdata;
        log_n++;
        mem_ready = 1'b1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_one(input int idx, input bit mode, input int l);
    logic [15:0]     pc;
    logic [7:0]      sc, cb;
    logic [SP_W-1:0] sp;
    int              npush, base, hb;
    logic [7:0]      exp_b [4];
    bit              got;
    pc = 16'hA000 + 16'(idx * 257) + 16'(mode);
    sc = 8'(idx) ^ 8'h3C;
    cb = 8'h80 | 8'(idx);
    sp = 16'h4000 + 16'(idx * 3);
    npush = (idx == 0) ? 0 : (mode ? 4 : 3);
    if (mode) begin
      exp_b[0] = cb; exp_b[1] = pc[15:8]; exp_b[2] = pc[7:0]; exp_b[3] = sc;
    end else begin
      exp_b[0] = pc[15:8]; exp_b[1] = pc[7:0]; exp_b[2] = sc; exp_b[3] = 8'h00;
    end
    @(negedge clk);
    lat = l;
    hb = hold_bad;
    req_index = IDX_W'(idx); mode_max = mode;
    cur_pc = pc; cur_sc = sc; cur_cb = cb; cur_sp = sp;
    req_valid = 1'b1; instr_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: pending request without completed instruction is held off
    chk(!mem_req && !busy, "R1", {30'd0, mem_req, busy}, 32'd0);
    base = log_n;
    instr_done = 1'b1;
    @(negedge clk);
    // R8: new request and changed context while busy
    req_index = IDX_W'(idx) ^ 7'h55; mode_max = !mode;
    cur_pc = ~pc; cur_sc = ~sc; cur_cb = ~cb; cur_sp = ~sp;
    got = 1'b0;
    for (int t = 0; t < 300; t++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    req_valid = 1'b0; instr_done = 1'b0;
    chk(got, "R5 done", {31'd0, got}, 32'd1);
    chk(log_n - base == npush + 2, "R8 access count", 32'(log_n - base),
        32'(npush + 2));
    for (int k = 0; k < npush; k++) begin
      int e;
      e = (base + k) % 16;
      // R2 / R3 push order and addresses
      chk(log_we[e] && log_addr[e] == ADDR_W'(sp - 16'(k + 1)),
          mode ? "R3 push addr" : "R2 push addr", 32'(log_addr[e]),
          32'(sp - 16'(k + 1)));
      chk(log_wd[e] == exp_b[k], mode ? "R3 push data" : "R2 push data",
          32'(log_wd[e]), 32'(exp_b[k]));
    end
    for (int k = 0; k < 2; k++) begin
      int e;
      e = (base + npush + k) % 16;
      chk(!log_we[e] && log_addr[e] == ADDR_W'(2 * idx + k),
          (idx == 0) ? "R6 vector read" : "R4 vector read",
          32'(log_addr[e]), 32'(2 * idx + k));
    end
    chk(new_pc == {vec_byte(ADDR_W'(2 * idx + 1)), vec_byte(ADDR_W'(2 * idx))},
        "R5 new_pc", 32'(new_pc),
        32'({vec_byte(ADDR_W'(2 * idx + 1)), vec_byte(ADDR_W'(2 * idx))}));
    chk(new_sp == sp - 16'(npush), (idx == 0) ? "R6 new_sp" : "R5 new_sp",
        32'(new_sp), 32'(sp - 16'(npush)));
    chk(hold_bad == hb, "R7 hold", 32'(hold_bad), 32'(hb));
    @(negedge clk);
    chk(!done && !busy, "R5 pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!mem_req && !done && !busy && new_pc == 16'd0 && new_sp == '0, "R9",
        {new_pc, 13'd0, mem_req, done, busy}, 32'd0);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < (1 << IDX_W); i++) begin
        run_one(i, m[0], (i + m) % 3);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule